// File: doc/BRIEF.md
# Hot-Reset Link-Training Hold Controller

This block sits beside a PCIe endpoint core and owns the enable that allows the link-training state machine to run. Software sets a training enable through a control register. When the hold feature is armed, a hot reset or link-down reset pulse clears the training enable in hardware. The enable stays low until software writes a one-shot release strobe. In that window firmware can rewrite core registers before the link retrains.

Software uses an APB-style register port with zero wait states. Control writes are masked halfword writes: bits [31:16] of the write data act as per-bit write enables for bits [15:0]. Each reset event also latches a write-one-to-clear status bit and raises an interrupt line. The interrupt handler reads the status word, writes the same value back, performs its reprogramming and then issues the release strobe.

Top module: `train_gate_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `train_en_o` and `irq_o` are 0, and both registers read 0.
- R2: A write to the control register at offset 0x180 changes a data bit n (n < 16) only when write-data bit n+16 is 1. Write data with a zero mask leaves the register unchanged.
- R3: Control bit 0 is the software training enable. With no hold active, `train_en_o` equals this bit from the cycle after the write.
- R4: Control bit 1 (hold enable) and control bit 4 (enhanced enable mode) together arm the hold. When both are 1, a `rst_evt_i` pulse drives `train_en_o` low from the next cycle.
- R5: A hold lasts until a control write with mask bit 19 and data bit 3 both set (the release strobe). `train_en_o` then follows bit 0 again from the next cycle.
- R6: Control bit 3 always reads back 0. A release strobe with no hold active does not change `train_en_o`.
- R7: A reset event does not clear the hold-enable bit, so every later event is held again without being re-armed.
- R8: If the hold is not armed (bit 1 or bit 4 is 0), a reset event leaves `train_en_o` unchanged.
- R9: An event that arrives while a hold is already active keeps the hold. A single release strobe still ends it.
- R10: Each reset event sets bit 0 of the status register at offset 0x010 and drives `irq_o` high from the next cycle. Writing 1 to bit 0 clears it, and writing 0 leaves it set.
- R11: If a reset event and a release strobe take effect in the same cycle, the event wins and the hold stays active.
- R12: Reads of any offset other than 0x180 and 0x010 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during a read access |
| rst_evt_i | input | 1 | One-cycle hot reset / link-down reset pulse |
| train_en_o | output | 1 | Link-training enable to the LTSSM |
| irq_o | output | 1 | Link-request-reset interrupt |

## Verification
The assertions check on every cycle that an armed event forces the training enable low on the next cycle. They also check that the hold survives until a release strobe appears, that an event always raises the interrupt, that the hold-enable bit survives events, that an unarmed event leaves the enable alone, and that the strobe bit reads as 0. Only the bench scenarios show the full software sequences: masked writes that must not take effect, write-one-to-clear with zero data, a second event during a hold, an event that coincides with the release write, and the reset state reached in the middle of a run.

// File: rtl/tgc_pkg.sv
// Package: shared offsets and bit positions of the training-gate controller.
// Assumes byte-addressed 32-bit registers in a 4 KiB client window.
package tgc_pkg;
    localparam int ADDR_W        = 12;
    localparam int DATA_W        = 32;
    localparam int HALF_W        = DATA_W / 2;
    localparam logic [ADDR_W-1:0] CTRL_OFS = 12'h180;
    localparam logic [ADDR_W-1:0] STAT_OFS = 12'h010;
    localparam int BIT_SW_EN     = 0;
    localparam int BIT_HOLD_EN   = 1;
    localparam int BIT_RELEASE   = 3;
    localparam int BIT_ENH_MODE  = 4;
    localparam int BIT_LRR_STAT  = 0;
endpackage

// File: rtl/tgc_ctrl_regs.sv
// Control register with masked-halfword writes.
// Stores the software enable, the hold enable and the enhanced mode bits.
// Bit 3 produces a one-cycle release pulse and is never stored.
// Assumes wr_en is a single-cycle qualified write strobe.
module tgc_ctrl_regs #(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [HALF_W-1:0] wdata,
    input  logic [HALF_W-1:0] wmask,
    output logic              sw_en,
    output logic              hold_en,
    output logic              enh_en,
    output logic              release_pulse,
    output logic [HALF_W-1:0] rd_val
);
    import tgc_pkg::*;

    // Update each stored bit only where its mask bit is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_en   <= 1'b0;
            hold_en <= 1'b0;
            enh_en  <= 1'b0;
        end else if (wr_en) begin
            if (wmask[BIT_SW_EN])    sw_en   <= wdata[BIT_SW_EN];
            if (wmask[BIT_HOLD_EN])  hold_en <= wdata[BIT_HOLD_EN];
            if (wmask[BIT_ENH_MODE]) enh_en  <= wdata[BIT_ENH_MODE];
        end
    end

    // Release strobe: a masked write of 1 to the release bit.
    assign release_pulse = wr_en && wmask[BIT_RELEASE] && wdata[BIT_RELEASE];

    // Read view: stored bits in place, everything else zero.
    always_comb begin
        rd_val               = '0;
        rd_val[BIT_SW_EN]    = sw_en;
        rd_val[BIT_HOLD_EN]  = hold_en;
        rd_val[BIT_ENH_MODE] = enh_en;
    end
endmodule

// File: rtl/tgc_hold.sv
// Hold flag: set by an armed reset event, cleared by the release pulse.
// An event in the same cycle as the release pulse takes priority.
// Assumes evt is a single-cycle pulse synchronous to clk.
module tgc_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic armed,
    input  logic release_pulse,
    output logic hold_q
);
    // Track whether link training is being held back.
    always_ff @(posedge clk) begin
        if (!rst_n)                hold_q <= 1'b0;
        else if (evt && armed)     hold_q <= 1'b1;
        else if (release_pulse)    hold_q <= 1'b0;
    end
endmodule

// File: rtl/tgc_status.sv
// Write-one-to-clear status for link-request-reset events, plus the interrupt.
// A new event in the same cycle as a clear leaves the bit set.
module tgc_status #(
    parameter int N_BITS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_BITS-1:0] set_bits,
    input  logic              clr_wr,
    input  logic [N_BITS-1:0] clr_bits,
    output logic [N_BITS-1:0] stat_q,
    output logic              irq
);
    // One sticky bit per event source; a set wins over a clear.
    for (genvar i = 0; i < N_BITS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)                    stat_q[i] <= 1'b0;
            else if (set_bits[i])          stat_q[i] <= 1'b1;
            else if (clr_wr && clr_bits[i]) stat_q[i] <= 1'b0;
        end
    end

    // The interrupt is high while any status bit is pending.
    assign irq = |stat_q;
endmodule

// File: rtl/train_gate_ctrl.sv
// Top level: register port decode, control register, hold flag and status.
// train_en_o is the software enable masked by the hold flag.
// Assumes zero-wait-state accesses and a one-cycle rst_evt_i pulse.
module train_gate_ctrl #(
    parameter int ADDR_W = tgc_pkg::ADDR_W,
    parameter int DATA_W = tgc_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic              rst_evt_i,
    output logic              train_en_o,
    output logic              irq_o
);
    import tgc_pkg::*;
    localparam int HW = DATA_W / 2;

    logic          wr_acc, hit_ctrl, hit_stat;
    logic          sw_en_q, hold_en_q, enh_en_q, rel_pulse, hold_q;
    logic [HW-1:0] ctrl_rd;
    logic [0:0]    stat_q;
    logic          unused_wbits;

    // Address decode and write qualification.
    assign hit_ctrl = (paddr == CTRL_OFS[ADDR_W-1:0]);
    assign hit_stat = (paddr == STAT_OFS[ADDR_W-1:0]);
    assign wr_acc   = psel && penable && pwrite;
    assign unused_wbits = ^pwdata[HW-1:1];

    tgc_ctrl_regs #(.HALF_W(HW)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_acc && hit_ctrl),
        .wdata         (pwdata[HW-1:0]),
        .wmask         (pwdata[DATA_W-1:HW]),
        .sw_en         (sw_en_q),
        .hold_en       (hold_en_q),
        .enh_en        (enh_en_q),
        .release_pulse (rel_pulse),
        .rd_val        (ctrl_rd)
    );

    tgc_hold u_hold (
        .clk           (clk),
        .rst_n         (rst_n),
        .evt           (rst_evt_i),
        .armed         (hold_en_q && enh_en_q),
        .release_pulse (rel_pulse),
        .hold_q        (hold_q)
    );

    tgc_status #(.N_BITS(1)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (rst_evt_i),
        .clr_wr   (wr_acc && hit_stat),
        .clr_bits (pwdata[BIT_LRR_STAT]),
        .stat_q   (stat_q),
        .irq      (irq_o)
    );

    // Gate the training enable with the hold flag.
    assign train_en_o = sw_en_q && !hold_q;

    // Read data mux; zero outside read accesses and for unmapped offsets.
    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            if (hit_ctrl)      prdata[HW-1:0]       = ctrl_rd;
            else if (hit_stat) prdata[BIT_LRR_STAT] = stat_q[0];
        end
    end
endmodule

// File: rtl/train_gate_chk.sv
// Checker for train_gate_ctrl: relates events, the hold and the outputs over time.
// Bound into every instance of the top module.
module train_gate_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] pwdata,
    input logic [DATA_W-1:0] prdata,
    input logic              rst_evt_i,
    input logic              train_en_o,
    input logic              irq_o,
    input logic              hold_en_q,
    input logic              enh_en_q,
    input logic              hold_q
);
    localparam int HW = DATA_W / 2;
    logic ctrl_wr, rel_wr;
    assign ctrl_wr = psel && penable && pwrite && (paddr == 12'h180);
    assign rel_wr  = ctrl_wr && pwdata[HW+3] && pwdata[3];

    a_r4_armed_event_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_evt_i && hold_en_q && enh_en_q) |=> !train_en_o);

    a_r5_hold_until_release: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !rel_wr) |=> hold_q);

    a_r7_hold_en_survives: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_evt_i && !ctrl_wr) |=> $stable(hold_en_q));

    a_r8_unarmed_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_evt_i && !(hold_en_q && enh_en_q) && !hold_q && !ctrl_wr)
        |=> (train_en_o == $past(train_en_o)));

    a_r10_event_irq: assert property (@(posedge clk) disable iff (!rst_n)
        rst_evt_i |=> irq_o);

    a_r6_release_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && paddr == 12'h180) |-> !prdata[3]);
endmodule

bind train_gate_ctrl train_gate_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .psel       (psel),
    .penable    (penable),
    .pwrite     (pwrite),
    .paddr      (paddr),
    .pwdata     (pwdata),
    .prdata     (prdata),
    .rst_evt_i  (rst_evt_i),
    .train_en_o (train_en_o),
    .irq_o      (irq_o),
    .hold_en_q  (hold_en_q),
    .enh_en_q   (enh_en_q),
    .hold_q     (hold_q)
);

// File: tb/train_gate_ctrl_bench.sv
module train_gate_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        rst_evt_i = 1'b0;
    logic        train_en_o, irq_o;
    int          checks = 0, errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    train_gate_ctrl u_train_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .rst_evt_i(rst_evt_i), .train_en_o(train_en_o), .irq_o(irq_o)
    );

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_EV = 2'd2;
    localparam int NV = 26;
    // {op, addr, data-or-expected-read, exp_train_en, exp_irq}
    localparam logic [47:0] VEC [NV] = '{
        {OP_WR, 12'h180, 32'h0001_0001, 1'b1, 1'b0}, // R3 sw enable on
        {OP_RD, 12'h180, 32'h0000_0001, 1'b1, 1'b0}, // R2 readback
        {OP_WR, 12'h180, 32'h0012_0012, 1'b1, 1'b0}, // R4 arm hold + enhanced
        {OP_RD, 12'h180, 32'h0000_0013, 1'b1, 1'b0}, // R2
        {OP_WR, 12'h180, 32'h0000_0000, 1'b1, 1'b0}, // R2 zero mask
        {OP_RD, 12'h180, 32'h0000_0013, 1'b1, 1'b0}, // R2
        {OP_WR, 12'h180, 32'h0000_0012, 1'b1, 1'b0}, // R2 data without mask
        {OP_EV, 12'h000, 32'h0,         1'b0, 1'b1}, // R4 R10 held, irq
        {OP_RD, 12'h010, 32'h0000_0001, 1'b0, 1'b1}, // R10 status set
        {OP_WR, 12'h010, 32'h0000_0000, 1'b0, 1'b1}, // R10 write 0 keeps
        {OP_WR, 12'h010, 32'h0000_0001, 1'b0, 1'b0}, // R10 W1C
        {OP_RD, 12'h180, 32'h0000_0013, 1'b0, 1'b0}, // R7 R6 still armed, bit3 0
        {OP_EV, 12'h000, 32'h0,         1'b0, 1'b1}, // R9 event during hold
        {OP_WR, 12'h180, 32'h0008_0008, 1'b1, 1'b1}, // R5 R9 single release
        {OP_WR, 12'h010, 32'h0000_0001, 1'b1, 1'b0}, // R10 clear
        {OP_EV, 12'h000, 32'h0,         1'b0, 1'b1}, // R7 held again
        {OP_WR, 12'h180, 32'h0000_0008, 1'b0, 1'b1}, // R5 unmasked release ignored
        {OP_WR, 12'h180, 32'h0008_0008, 1'b1, 1'b1}, // R5 release
        {OP_WR, 12'h010, 32'h0000_0001, 1'b1, 1'b0}, // R10 clear
        {OP_WR, 12'h180, 32'h0008_0008, 1'b1, 1'b0}, // R6 release with no hold
        {OP_WR, 12'h180, 32'h0002_0000, 1'b1, 1'b0}, // R8 disarm hold
        {OP_RD, 12'h180, 32'h0000_0011, 1'b1, 1'b0}, // R2 R8
        {OP_EV, 12'h000, 32'h0,         1'b1, 1'b1}, // R8 unarmed event
        {OP_WR, 12'h180, 32'h0001_0000, 1'b0, 1'b1}, // R3 sw enable off
        {OP_WR, 12'h180, 32'h0001_0001, 1'b1, 1'b1}, // R3 on again
        {OP_RD, 12'h004, 32'h0000_0000, 1'b1, 1'b1}  // R12 unmapped
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic evt);
        @(negedge clk); psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk); penable = 1'b1; rst_evt_i = evt;
        @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0; rst_evt_i = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk); penable = 1'b1; #1 d = prdata;
        @(negedge clk); psel = 1'b0; penable = 1'b0;
    endtask

    task automatic pulse_event();
        @(negedge clk); rst_evt_i = 1'b1;
        @(negedge clk); rst_evt_i = 1'b0;
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "train_en", {31'b0, train_en_o}, 32'h0);
        check("R1", "irq", {31'b0, irq_o}, 32'h0);
        rst_n = 1'b1;
        bus_read(12'h180, rd); check("R1", "ctrl read", rd, 32'h0);
        bus_read(12'h010, rd); check("R1", "status read", rd, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [47:0] v;
            v = VEC[i];
            case (v[47:46])
                OP_WR: bus_write(v[45:34], v[33:2], 1'b0);
                OP_RD: begin
                    bus_read(v[45:34], rd);
                    check($sformatf("vec%0d", i), "read", rd, v[33:2]);
                end
                default: pulse_event();
            endcase
            check($sformatf("vec%0d", i), "train_en", {31'b0, train_en_o}, {31'b0, v[1]});
            check($sformatf("vec%0d", i), "irq", {31'b0, irq_o}, {31'b0, v[0]});
        end

        // R11: event coincides with the release write; the hold must stay
        bus_write(12'h180, 32'h0002_0002, 1'b0);
        pulse_event();
        check("R4", "held before R11", {31'b0, train_en_o}, 32'h0);
        bus_write(12'h180, 32'h0008_0008, 1'b1);
        check("R11", "event beats release", {31'b0, train_en_o}, 32'h0);
        bus_write(12'h180, 32'h0008_0008, 1'b0);
        check("R11", "later release", {31'b0, train_en_o}, 32'h1);

        // R8: hold enable set but enhanced mode clear means not armed
        bus_write(12'h180, 32'h0010_0000, 1'b0);
        pulse_event();
        check("R8", "enhanced off", {31'b0, train_en_o}, 32'h1);

        // R1: reset in mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1", "mid reset train_en", {31'b0, train_en_o}, 32'h0);
        check("R1", "mid reset irq", {31'b0, irq_o}, 32'h0);
        rst_n = 1'b1;
        bus_read(12'h180, rd); check("R1", "mid reset ctrl", rd, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule